// File: doc/BRIEF.md
# Reference Clock Pre-Divider

This block sits between a reference clock input and a phase detector. The reference level arrives already sampled in the system clock domain. The block picks out one edge polarity of that level and reduces the edge stream to the rate at which phase comparisons are made. It emits a one-cycle strobe for every comparison event.

There are three lock modes. Direct mode compares at the input's own rate, except that the top 155.52 MHz rate is always halved to stay under the 77.76 MHz comparison ceiling. The 8 kHz mode derives its ratio from a spot-frequency code. Manual mode divides by a programmable integer N+1. The manual value is meant to be shared across all inputs that use manual mode, so those inputs must run at one common frequency. Software chooses N so that the divided rate is 8 kHz, for example N=249 for a 2 MHz input or N=1249 for a 10 MHz input.

Top module: `ref_prediv`

## Requirements
- R1: With mode 0 (direct) and any spot code other than 11, every selected edge gives a one-cycle `divStrobe` in the cycle after the clock edge that samples it.
- R2: With mode 0 and spot code 11 (155.52 MHz), `divStrobe` fires on every second selected edge.
- R3: With mode 1 (8 kHz), the ratio is the spot frequency divided by 8 kHz: code 3 (1.544 MHz) gives 193, 4 (2.048 MHz) 256, 5 (6.48 MHz) 810, 6 (19.44 MHz) 2430, 7 (25.92 MHz) 3240, 8 (38.88 MHz) 4860, 9 (51.84 MHz) 6480, 10 (77.76 MHz) 9720, 11 (155.52 MHz) 19440.
- R4: With mode 1, codes 0, 1 and 2 (2, 4, 8 kHz) pass every selected edge, and codes 12 to 15 give no strobe.
- R5: With mode 2 (manual), the ratio is N+1 for N from 1 to 15624.
- R6: With mode 2 and N equal to 0 or above 15624, no strobe is produced.
- R7: With `polarity` 0, rising edges of `refLevel` are counted. With `polarity` 1, falling edges are counted.
- R8: A change of mode, spot code, N or polarity clears the edge count, and an edge seen in the cycle of the change is not counted.
- R9: Reset holds `divStrobe` low and clears the count, so the first strobe after reset needs a full ratio of edges.
- R10: Mode 3 is reserved and gives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| refLevel | input | 1 | Reference clock level, sampled in the clk domain |
| polarity | input | 1 | 0 counts rising edges, 1 counts falling edges |
| mode | input | 2 | 0 direct, 1 divide to 8 kHz, 2 manual, 3 reserved |
| spotCode | input | 4 | Spot frequency code, 0..11 as listed in R3/R4 |
| nValue | input | 14 | Manual divider value N (ratio N+1) |
| divStrobe | output | 1 | One-cycle comparison event |

## Verification
The bench builds the block with its default parameters: a 14-bit N limited to 15624 and a 15-bit counter. This brings the full manual range and the largest 8 kHz ratio of 19440 within a single run. The two extreme ratios, 15625 and 19440, are each driven through a complete terminal count. The out-of-range N values 0 and 15625 sit directly next to the legal limits.

// File: rtl/refdiv_pkg.sv
package refdiv_pkg;

  typedef enum logic [1:0] {
    MODE_DIRECT = 2'd0,
    MODE_LOCK8K = 2'd1,
    MODE_MANUAL = 2'd2,
    MODE_RSVD   = 2'd3
  } divMode_e;

  localparam logic [3:0] SPOT_TOP = 4'd11;

  typedef struct packed {
    logic edgeHit;
    logic clear;
  } divCtl_t;

  // Ratio from spot rate down to 8 kHz; 0 marks an unsupported code.
  function automatic logic [15:0] lock8kRatio(input logic [3:0] code);
    logic [15:0] r;
    case (code)
      4'd0, 4'd1, 4'd2: r = 16'd1;
      4'd3:  r = 16'd193;
      4'd4:  r = 16'd256;
      4'd5:  r = 16'd810;
      4'd6:  r = 16'd2430;
      4'd7:  r = 16'd3240;
      4'd8:  r = 16'd4860;
      4'd9:  r = 16'd6480;
      4'd10: r = 16'd9720;
      4'd11: r = 16'd19440;
      default: r = 16'd0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/refdiv_ctrl.sv
module refdiv_ctrl
  import refdiv_pkg::*;
#(
  parameter int N_W   = 14,
  parameter int N_MAX = 15624,
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             refLevel,
  input  logic             polarity,
  input  logic [1:0]       mode,
  input  logic [3:0]       spotCode,
  input  logic [N_W-1:0]   nValue,
  output divCtl_t          ctl,
  output logic [CNT_W-1:0] ratio
);
  localparam int CFG_W = 2 + 4 + N_W + 1;

  logic             lvlQ;
  logic [CFG_W-1:0] cfgNow, cfgQ;
  logic             selEdge, cfgChanged, nInRange;

  assign cfgNow = {mode, spotCode, nValue, polarity};

  // Tracking registers load every cycle, reset included.
  always_ff @(posedge clk) begin
    lvlQ <= refLevel;
    cfgQ <= cfgNow;
  end

  assign selEdge    = polarity ? (lvlQ & ~refLevel) : (refLevel & ~lvlQ);
  assign cfgChanged = (cfgNow != cfgQ);
  assign nInRange   = (nValue != '0) && (int'(nValue) <= N_MAX);

  always_comb begin
    unique case (divMode_e'(mode))
      MODE_DIRECT: ratio = (spotCode == SPOT_TOP) ? CNT_W'(2) : CNT_W'(1);
      MODE_LOCK8K: ratio = CNT_W'(lock8kRatio(spotCode));
      MODE_MANUAL: ratio = nInRange ? (CNT_W'(nValue) + CNT_W'(1)) : '0;
      default:     ratio = '0;
    endcase
  end

  assign ctl.clear   = cfgChanged;
  assign ctl.edgeHit = selEdge & (ratio != '0) & ~cfgChanged;

endmodule

// File: rtl/refdiv_count.sv
module refdiv_count
  import refdiv_pkg::*;
#(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtl_t          ctl,
  input  logic [CNT_W-1:0] ratio,
  output logic             divStrobe
);
  logic [CNT_W-1:0] cnt;
  logic             atTerm;

  assign atTerm = ({1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1}) == {1'b0, ratio};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt       <= '0;
      divStrobe <= 1'b0;
    end else begin
      divStrobe <= 1'b0;
      if (ctl.clear) begin
        cnt <= '0;
      end else if (ctl.edgeHit) begin
        if (atTerm) begin
          cnt       <= '0;
          divStrobe <= 1'b1;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

endmodule

// File: rtl/ref_prediv.sv
module ref_prediv
  import refdiv_pkg::*;
#(
  parameter int N_W   = 14,
  parameter int N_MAX = 15624,
  parameter int CNT_W = 15
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           refLevel,
  input  logic           polarity,
  input  logic [1:0]     mode,
  input  logic [3:0]     spotCode,
  input  logic [N_W-1:0] nValue,
  output logic           divStrobe
);
  divCtl_t          ctl;
  logic [CNT_W-1:0] ratio;

  refdiv_ctrl #(.N_W(N_W), .N_MAX(N_MAX), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .refLevel(refLevel), .polarity(polarity), .mode(mode),
    .spotCode(spotCode), .nValue(nValue), .ctl(ctl), .ratio(ratio)
  );

  refdiv_count #(.CNT_W(CNT_W)) uCount (
    .clk(clk), .rstN(rstN), .ctl(ctl), .ratio(ratio), .divStrobe(divStrobe)
  );

endmodule

// File: rtl/refdiv_checker.sv
module refdiv_checker #(
  parameter int N_W   = 14,
  parameter int N_MAX = 15624
) (
  input logic           clk,
  input logic           rstN,
  input logic           refLevel,
  input logic           polarity,
  input logic [1:0]     mode,
  input logic [3:0]     spotCode,
  input logic [N_W-1:0] nValue,
  input logic           divStrobe
);
  logic [N_W+6:0] cfg;
  assign cfg = {mode, spotCode, nValue, polarity};

  // R1: direct mode passes each selected edge under a steady setting
  a_r1_direct_pass: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd0 && spotCode != 4'd11 && $stable(cfg) &&
     (polarity ? (!refLevel && $past(refLevel)) : (refLevel && !$past(refLevel))))
    |=> divStrobe);

  // R7: nothing comes out without an edge of the selected polarity
  a_r7_needs_edge: assert property (@(posedge clk) disable iff (!rstN)
    !(polarity ? (!refLevel && $past(refLevel)) : (refLevel && !$past(refLevel)))
    |=> !divStrobe);

  // R6: illegal manual N is silent
  a_r6_bad_n_silent: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd2 && (nValue == '0 || int'(nValue) > N_MAX)) |=> !divStrobe);

  // R8: setting change drops that cycle's edge
  a_r8_change_drops: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cfg) |=> !divStrobe);

  // R10: reserved mode is silent
  a_r10_rsvd_silent: assert property (@(posedge clk) disable iff (!rstN)
    (mode == 2'd3) |=> !divStrobe);

endmodule

bind ref_prediv refdiv_checker #(.N_W(N_W), .N_MAX(N_MAX)) uChk (
  .clk(clk), .rstN(rstN), .refLevel(refLevel), .polarity(polarity),
  .mode(mode), .spotCode(spotCode), .nValue(nValue), .divStrobe(divStrobe)
);

// File: tb/ref_prediv_test.sv
`timescale 1ns/1ps
module ref_prediv_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        refLevel = 1'b0;
  logic        polarity = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic [3:0]  spotCode = 4'd0;
  logic [13:0] nValue = 14'd1;
  logic        divStrobe;

  int checks = 0, fails = 0, pulseCnt = 0;
  string curTag = "R9";
  bit done = 0;

  always #2 clk = ~clk;

  ref_prediv uut (.clk(clk), .rstN(rstN), .refLevel(refLevel), .polarity(polarity),
    .mode(mode), .spotCode(spotCode), .nValue(nValue), .divStrobe(divStrobe));

  // Behavioural reference model
  int  mCnt = 0;
  bit  mPrevLvl = 0, mExp = 0;
  logic [20:0] mPrevCfg = '0;

  function automatic int spotKhz(input int code);
    int t[12] = '{2, 4, 8, 1544, 2048, 6480, 19440, 25920, 38880, 51840, 77760, 155520};
    return (code < 12) ? t[code] : 0;
  endfunction

  function automatic int modelRatio(input int m, input int s, input int n);
    if (m == 0) return (s == 11) ? 2 : 1;
    if (m == 1) begin
      if (s >= 12) return 0;
      return (spotKhz(s) < 8) ? 1 : spotKhz(s) / 8;
    end
    if (m == 2) return (n >= 1 && n <= 15624) ? n + 1 : 0;
    return 0;
  endfunction

  always @(posedge clk) begin
    logic [20:0] cfg;
    bit edgeSeen;
    int r;
    cfg = {mode, spotCode, nValue, polarity};
    mExp = 0;
    if (!rstN) begin
      mCnt = 0;
    end else begin
      edgeSeen = polarity ? (mPrevLvl && !refLevel) : (!mPrevLvl && refLevel);
      r = modelRatio(mode, spotCode, nValue);
      if (cfg != mPrevCfg) mCnt = 0;
      else if (edgeSeen && r != 0) begin
        mCnt++;
        if (mCnt == r) begin mExp = 1; mCnt = 0; end
      end
    end
    mPrevLvl = refLevel;
    mPrevCfg = cfg;
  end

  always @(negedge clk) begin
    if (!done) begin
      checks++;
      if (divStrobe !== mExp) begin
        fails++;
        $display("FAIL %s cycle compare: divStrobe=%0b expected=%0b at %0t", curTag, divStrobe, mExp, $time);
      end
      if (divStrobe === 1'b1) pulseCnt++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s pulses: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic edges(input int e);
    for (int i = 0; i < e; i++) begin
      @(negedge clk) refLevel = 1'b1;
      @(negedge clk) refLevel = 1'b0;
    end
  endtask

  task automatic phase(input string tag, input int m, input int s, input int n,
                       input bit pol, input int e, input int expPulses);
    curTag = tag;
    @(negedge clk);
    mode = m[1:0]; spotCode = s[3:0]; nValue = n[13:0]; polarity = pol; refLevel = pol;
    repeat (2) @(negedge clk);
    pulseCnt = 0;
    if (pol) begin
      for (int i = 0; i < e; i++) begin
        @(negedge clk) refLevel = 1'b0;
        @(negedge clk) refLevel = 1'b1;
      end
    end else edges(e);
    repeat (3) @(negedge clk);
    check(tag, pulseCnt, expPulses);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    check("R9 reset output", int'(divStrobe), 0);
    rstN = 1'b1;
    phase("R1", 0, 6, 1, 0, 20, 20);
    phase("R2", 0, 11, 1, 0, 21, 10);
    phase("R3", 1, 3, 1, 0, 400, 2);
    phase("R3", 1, 11, 1, 0, 19440, 1);
    phase("R4", 1, 1, 1, 0, 10, 10);
    phase("R4", 1, 13, 1, 0, 10, 0);
    phase("R5", 2, 0, 249, 0, 500, 2);
    phase("R5", 2, 0, 1, 0, 9, 4);
    phase("R5", 2, 0, 15624, 0, 15625, 1);
    phase("R6", 2, 0, 0, 0, 10, 0);
    phase("R6", 2, 0, 15625, 0, 10, 0);
    phase("R10", 3, 0, 5, 0, 10, 0);
    phase("R7", 0, 6, 1, 1, 10, 10);
    // R8: change N on the same cycle as a rising edge
    phase("R8", 2, 0, 3, 0, 6, 1);
    curTag = "R8";
    pulseCnt = 0;
    @(negedge clk) begin refLevel = 1'b1; nValue = 14'd4; end
    @(negedge clk) refLevel = 1'b0;
    edges(4);
    repeat (2) @(negedge clk);
    check("R8 count cleared and edge dropped", pulseCnt, 0);
    edges(1);
    repeat (2) @(negedge clk);
    check("R8 fifth edge after change", pulseCnt, 1);
    // R9: reset mid-count clears the count
    phase("R9", 2, 0, 3, 0, 2, 0);
    curTag = "R9";
    @(negedge clk) rstN = 1'b0;
    @(negedge clk) rstN = 1'b1;
    pulseCnt = 0;
    edges(3);
    repeat (2) @(negedge clk);
    check("R9 three edges after reset", pulseCnt, 0);
    edges(1);
    repeat (2) @(negedge clk);
    check("R9 fourth edge after reset", pulseCnt, 1);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(190000 * 4);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule